// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a memory effective address from up to three terms: an optional base register, an optional index register multiplied by a power-of-two scale, and a sign-extended displacement of zero, one, two or four bytes. The eight 32-bit general registers are presented to it as one flattened input vector. The block picks the base and index values from that vector, scales the index by shifting it, and adds the three terms modulo 2^32.

A request is launched by asserting `req_vld` together with the operand description. One clock edge later the result appears on `ea_addr` with `ea_vld` high. A request that names register 4 (the stack pointer) as the index is an illegal encoding: it is flagged on `ea_bad` and its address is forced to zero. Register 4 remains legal as a base. The address forms covered are displacement only, base only, base plus displacement, base plus index, and the full scaled-index form with or without a displacement.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low and after its release until the first request, `ea_vld`, `ea_bad` and `ea_addr` are all zero.
- R2: `ea_vld` is high in exactly the cycle after an edge that samples `req_vld` high. After an edge that samples `req_vld` low, `ea_vld` is low and `ea_addr` and `ea_bad` keep their previous values.
- R3: For a legal request, `ea_addr` equals base term + scaled index term + extended displacement, taken modulo 2^32.
- R4: `scale` selects the index multiplier: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R5: `disp_sz` selects the displacement: 00 gives zero. 01 gives `disp[7:0]` sign-extended. 10 gives `disp[15:0]` sign-extended. 11 gives all of `disp`. Bits above the selected size have no effect.
- R6: With `base_en` low the base term is zero and `base_sel` has no effect. With `base_en` high, any register 0 to 7, including 4, is a legal base.
- R7: With `idx_en` low the index term is zero, and `idx_sel` and `scale` have no effect.
- R8: When `idx_en` is high and `idx_sel` is 4, `ea_bad` is 1 and `ea_addr` is 0. In every other request `ea_bad` is 0.
- R9: Register k is read from `regs_flat[32k+31:32k]`, for k from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Launch a request this cycle |
| base_en | input | 1 | Base register present |
| base_sel | input | 3 | Base register number |
| idx_en | input | 1 | Index register present |
| idx_sel | input | 3 | Index register number |
| scale | input | 2 | Index scale code |
| disp_sz | input | 2 | Displacement size code |
| disp | input | 32 | Displacement bits |
| regs_flat | input | 256 | Eight registers, register k in bits 32k+31:32k |
| ea_vld | output | 1 | Result valid |
| ea_addr | output | 32 | Effective address |
| ea_bad | output | 1 | Illegal index encoding |

## Verification
The bench sweeps every base and index register pair under every scale, presence and displacement-size combination. It uses displacements whose sign bits vary, so that a design which zero-extends short displacements, or lets high displacement bits leak through, produces wrong addresses for negative byte and word offsets. Register contents are chosen so that sums wrap past 2^32, which exposes a design that carries into a wider result. Register 4 is exercised both as a base, which must stay legal, and as an index with the index term enabled and disabled, so that a design that rejects it in the wrong position, or ignores the presence bit, raises or drops `ea_bad` wrongly. Idle cycles with changing inputs catch a result register that updates without a request.

// File: rtl/ea_pkg.sv
package ea_pkg;
    // displacement size codes
    typedef enum logic [1:0] {
        DSZ_NONE = 2'b00,
        DSZ_B1   = 2'b01,
        DSZ_B2   = 2'b10,
        DSZ_B4   = 2'b11
    } dsz_e;
endpackage

// File: rtl/ea_reg_pick.sv
module ea_reg_pick #(
    parameter int XLEN  = 32,
    parameter int NREG  = 8,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic                 en,
    input  logic [SEL_W-1:0]     sel,
    input  logic [NREG*XLEN-1:0] regs_flat,
    output logic [XLEN-1:0]      val
);
    logic [XLEN-1:0] rf [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_unpack
        assign rf[k] = regs_flat[k*XLEN +: XLEN];
    end

    always_comb begin
        val = en ? rf[sel] : '0;
    end
endmodule

// File: rtl/ea_disp_ext.sv
module ea_disp_ext
    import ea_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      dsz,
    input  logic [XLEN-1:0] disp,
    output logic [XLEN-1:0] dext
);
    dsz_e code;

    always_comb begin
        code = dsz_e'(dsz);
        unique case (code)
            DSZ_NONE: dext = '0;
            DSZ_B1:   dext = {{(XLEN-8){disp[7]}}, disp[7:0]};
            DSZ_B2:   dext = {{(XLEN-16){disp[15]}}, disp[15:0]};
            DSZ_B4:   dext = disp;
            default:  dext = '0;
        endcase
    end
endmodule

// File: rtl/ea_combine.sv
module ea_combine #(
    parameter int XLEN   = 32,
    parameter int NREG   = 8,
    parameter int SP_NUM = 4,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic [XLEN-1:0]  base_val,
    input  logic [XLEN-1:0]  idx_val,
    input  logic [XLEN-1:0]  dext,
    input  logic [1:0]       scale,
    input  logic             idx_en,
    input  logic [SEL_W-1:0] idx_sel,
    output logic [XLEN-1:0]  addr,
    output logic             bad
);
    localparam logic [SEL_W-1:0] SP_SEL = SEL_W'(SP_NUM);

    logic [XLEN-1:0] scaled;

    always_comb begin
        scaled = idx_val << scale;
        bad    = idx_en && (idx_sel == SP_SEL);
        addr   = bad ? '0 : (base_val + scaled + dext);
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
    parameter int XLEN   = 32,
    parameter int NREG   = 8,
    parameter int SP_NUM = 4,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_vld,
    input  logic                 base_en,
    input  logic [SEL_W-1:0]     base_sel,
    input  logic                 idx_en,
    input  logic [SEL_W-1:0]     idx_sel,
    input  logic [1:0]           scale,
    input  logic [1:0]           disp_sz,
    input  logic [XLEN-1:0]      disp,
    input  logic [NREG*XLEN-1:0] regs_flat,
    output logic                 ea_vld,
    output logic [XLEN-1:0]      ea_addr,
    output logic                 ea_bad
);
    logic [XLEN-1:0] base_val;
    logic [XLEN-1:0] idx_val;
    logic [XLEN-1:0] dext;
    logic [XLEN-1:0] addr_d;
    logic            bad_d;

    ea_reg_pick #(.XLEN(XLEN), .NREG(NREG)) u_base (
        .en        (base_en),
        .sel       (base_sel),
        .regs_flat (regs_flat),
        .val       (base_val)
    );

    ea_reg_pick #(.XLEN(XLEN), .NREG(NREG)) u_idx (
        .en        (idx_en),
        .sel       (idx_sel),
        .regs_flat (regs_flat),
        .val       (idx_val)
    );

    ea_disp_ext #(.XLEN(XLEN)) u_disp (
        .dsz  (disp_sz),
        .disp (disp),
        .dext (dext)
    );

    ea_combine #(.XLEN(XLEN), .NREG(NREG), .SP_NUM(SP_NUM)) u_sum (
        .base_val (base_val),
        .idx_val  (idx_val),
        .dext     (dext),
        .scale    (scale),
        .idx_en   (idx_en),
        .idx_sel  (idx_sel),
        .addr     (addr_d),
        .bad      (bad_d)
    );

    // result register: loads only on a request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_vld  <= 1'b0;
            ea_addr <= '0;
            ea_bad  <= 1'b0;
        end else begin
            ea_vld <= req_vld;
            if (req_vld) begin
                ea_addr <= addr_d;
                ea_bad  <= bad_d;
            end
        end
    end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int XLEN   = 32,
    parameter int SEL_W  = 3,
    parameter int SP_NUM = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic             base_en,
    input logic             idx_en,
    input logic [SEL_W-1:0] idx_sel,
    input logic [1:0]       disp_sz,
    input logic             ea_vld,
    input logic [XLEN-1:0]  ea_addr,
    input logic             ea_bad
);
    localparam logic [SEL_W-1:0] SP_SEL = SEL_W'(SP_NUM);

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> ea_vld);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!ea_vld && $stable(ea_addr) && $stable(ea_bad)));

    // R8
    sp_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && idx_en && idx_sel == SP_SEL) |=> (ea_bad && ea_addr == '0));

    // R8
    legal_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !(idx_en && idx_sel == SP_SEL)) |=> !ea_bad);

    // R7
    empty_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !base_en && !idx_en && disp_sz == 2'b00) |=> (ea_addr == '0));
endmodule

bind ea_gen ea_gen_chk #(.XLEN(XLEN), .SEL_W(SEL_W), .SP_NUM(SP_NUM)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_vld (req_vld),
    .base_en (base_en),
    .idx_en  (idx_en),
    .idx_sel (idx_sel),
    .disp_sz (disp_sz),
    .ea_vld  (ea_vld),
    .ea_addr (ea_addr),
    .ea_bad  (ea_bad)
);

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic        base_en = 1'b0;
    logic [2:0]  base_sel = '0;
    logic        idx_en = 1'b0;
    logic [2:0]  idx_sel = '0;
    logic [1:0]  scale = '0;
    logic [1:0]  disp_sz = '0;
    logic [31:0] disp = '0;
    logic [255:0] regs_flat;
    logic        ea_vld;
    logic [31:0] ea_addr;
    logic        ea_bad;

    logic [31:0] rf [8];
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 8; k++) regs_flat[k*32 +: 32] = rf[k];
    end

    ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld),
        .base_en(base_en), .base_sel(base_sel),
        .idx_en(idx_en), .idx_sel(idx_sel),
        .scale(scale), .disp_sz(disp_sz), .disp(disp),
        .regs_flat(regs_flat),
        .ea_vld(ea_vld), .ea_addr(ea_addr), .ea_bad(ea_bad)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_addr();
        logic [31:0] b, i, d;
        int mult;
        if (idx_en && idx_sel == 3'd4) return 32'h0;
        b = base_en ? rf[base_sel] : 32'h0;
        i = idx_en ? rf[idx_sel] : 32'h0;
        mult = 1;
        for (int s = 0; s < int'(scale); s++) mult = mult * 2;
        case (disp_sz)
            2'd1: d = 32'(int'($signed(disp[7:0])));
            2'd2: d = 32'(int'($signed(disp[15:0])));
            2'd3: d = disp;
            default: d = 32'h0;
        endcase
        return b + i * 32'(mult) + d;
    endfunction

    // one request, checked after the launching edge
    task automatic issue(input string tag);
        logic [31:0] ea_exp;
        logic        bad_exp;
        req_vld = 1'b1;
        ea_exp  = model_addr();
        bad_exp = idx_en && idx_sel == 3'd4;
        @(negedge clk);
        chk({tag, " R2 vld"}, {31'h0, ea_vld}, 32'h1);
        chk({tag, " R8 bad"}, {31'h0, ea_bad}, {31'h0, bad_exp});
        chk({tag, " addr"}, ea_addr, ea_exp);
    endtask

    task automatic set_op(input logic be, input logic [2:0] bs, input logic ie,
                          input logic [2:0] is, input logic [1:0] sc,
                          input logic [1:0] dz, input logic [31:0] dv);
        base_en = be; base_sel = bs; idx_en = ie; idx_sel = is;
        scale = sc; disp_sz = dz; disp = dv;
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        int n;
        for (int k = 0; k < 8; k++) rf[k] = 32'h9E37_79B9 * 32'(k + 1);
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 vld", {31'h0, ea_vld}, 32'h0);
        chk("R1 addr", ea_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release vld", {31'h0, ea_vld}, 32'h0);
        chk("R1 after release bad", {31'h0, ea_bad}, 32'h0);
        chk("R1 after release addr", ea_addr, 32'h0);

        // R9 R4: base 0xf000 (reg2) + 4*index 0x100 (reg1)
        rf[2] = 32'h0000_F000; rf[1] = 32'h0000_0100;
        set_op(1, 3'd2, 1, 3'd1, 2'b10, 2'b00, 32'h0);
        issue("R4 R9 ex1");
        chk("R4 ex1 value", ea_addr, 32'h0000_F400);
        // R7-type: no base, scale 2, 4-byte disp 0x80, index 0xf000
        set_op(0, 3'd0, 1, 3'd2, 2'b01, 2'b11, 32'h0000_0080);
        issue("R6 ex2");
        chk("R6 ex2 value", ea_addr, 32'h0001_E080);
        // R5 negative byte displacement
        set_op(1, 3'd2, 0, 3'd0, 2'b00, 2'b01, 32'hABCD_EF80);
        issue("R5 negbyte");
        chk("R5 negbyte value", ea_addr, 32'h0000_EF80);
        // R3 wrap past 2^32
        rf[3] = 32'hFFFF_FFF0;
        set_op(1, 3'd3, 0, 3'd0, 2'b00, 2'b11, 32'h0000_0020);
        issue("R3 wrap");
        chk("R3 wrap value", ea_addr, 32'h0000_0010);
        // R6 register 4 as base is legal
        rf[4] = 32'h0000_1000;
        set_op(1, 3'd4, 0, 3'd4, 2'b11, 2'b00, 32'h0);
        issue("R6 sp base");
        chk("R7 sp idx disabled", ea_addr, 32'h0000_1000);
        // R8 register 4 as index
        set_op(1, 3'd1, 1, 3'd4, 2'b00, 2'b11, 32'h1234_5678);
        issue("R8 sp index");
        held = ea_addr;
        // R2 idle hold: inputs change, no request
        req_vld = 1'b0;
        set_op(1, 3'd5, 1, 3'd6, 2'b11, 2'b11, 32'h5555_AAAA);
        @(negedge clk);
        chk("R2 idle vld", {31'h0, ea_vld}, 32'h0);
        chk("R2 idle addr held", ea_addr, held);
        chk("R2 idle bad held", {31'h0, ea_bad}, 32'h1);

        // sweep all forms
        for (int k = 0; k < 8; k++) rf[k] = 32'h9E37_79B9 * 32'(k + 1) ^ 32'(k << 28);
        n = 0;
        for (int sc = 0; sc < 4; sc++)
            for (int be = 0; be < 2; be++)
                for (int ie = 0; ie < 2; ie++)
                    for (int bs = 0; bs < 8; bs++)
                        for (int is = 0; is < 8; is++)
                            for (int dz = 0; dz < 4; dz++) begin
                                set_op(1'(be), 3'(bs), 1'(ie), 3'(is), 2'(sc), 2'(dz),
                                       32'hA5C3_80F1 + 32'(n) * 32'h0101_7F93);
                                issue("R3/R4/R5/R6/R7/R8/R9 sweep");
                                n++;
                            end
        req_vld = 1'b0;
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule